// File: doc/BRIEF.md
# Configurable Output Lane Crossbar

This block sits between eight internal parallel lane streams and eight output transmitter lanes. Every output lane has its own 3-bit routing select, so any internal stream can be steered onto any output lane, and one stream may feed several lanes at once. Each output lane also has an enable bit. Software clears the enable of a lane it does not use so that the lane stays quiet and can be powered down further along the chain.

The selects and enables are held in a small byte-wide register file. A plain address, write-data and write-strobe bus writes it, and a combinational read port reads it back. The routing registers sit behind a page register. They accept writes and return data only while that page register holds the lane page value. At reset the routing is identity, so stream n appears on lane n and active data starts on lane 0, and every lane is enabled. The routed words and valid flags are registered once on the way out.

Top module: `lane_xbar`

## Requirements
- R1: After reset each output lane n carries internal stream n. Every select field reads back as its own lane index.
- R2: After reset every lane is enabled, and the enable register (address 0x84, bit n = lane n) reads 0xFF.
- R3: The page register at address 0x05 resets to 0x00 and can always be written and read. Writes to addresses 0x80 to 0x84 are ignored unless the page register holds 0x04. Reads of 0x80 to 0x84 return 0x00 when the page differs.
- R4: The select for lane 2k sits in bits [2:0] of address 0x80+k, and the select for lane 2k+1 sits in bits [6:4] of the same address (k = 0 to 3). For example, 0x54 at 0x81 routes stream 4 to lane 2 and stream 5 to lane 3.
- R5: Bits 3 and 7 of every select register read back as zero, whatever value was written to them.
- R6: A lane whose enable bit is 0 drives all-zero data and a deasserted valid flag.
- R7: An output word and its valid flag appear one clock edge after the input is presented. A register write captured at clock edge k routes the word registered at edge k+1. The word registered at edge k still uses the old setting.
- R8: Any stream can feed any number of lanes at the same time. The routed valid flag of a lane equals the input valid flag of the stream it selects.
- R9: A read of 0x80 to 0x84 under the lane page returns the value last stored there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register address for read and write |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Combinational read data for regAddr |
| laneInData | input | 8*DATA_W | Internal stream words, stream n in bits [n*DATA_W +: DATA_W] |
| laneInValid | input | 8 | Internal stream valid flags |
| laneOutData | output | 8*DATA_W | Routed output lane words, lane n in bits [n*DATA_W +: DATA_W] |
| laneOutValid | output | 8 | Routed output lane valid flags |
| laneOutEn | output | 8 | Current per-lane enable flags |

## Verification
Read data is combinational, so the bench samples it one nanosecond after it changes the address. Lane words are due at the first rising edge after the inputs are presented. The bench drives inputs on falling edges, lets exactly one rising edge pass, and samples on the next falling edge. A register write lands at the rising edge that captures the strobe. The latency scenario therefore checks that the word sampled right after that edge still follows the old routing, and that the word after one more edge follows the new routing. The expected outputs come from a routing and enable model in the bench that changes only through accepted writes.

// File: rtl/lane_xbar_pkg.sv
package lane_xbar_pkg;
  localparam int NUM_LANES    = 8;
  localparam int SEL_W        = $clog2(NUM_LANES);
  localparam int NUM_SEL_REGS = NUM_LANES / 2;
  localparam int ADDR_W       = 8;
  localparam int REG_W        = 8;

  localparam logic [ADDR_W-1:0] ADDR_PAGE  = 8'h05;
  localparam logic [ADDR_W-1:0] ADDR_SEL0  = 8'h80;
  localparam logic [ADDR_W-1:0] ADDR_EN    = 8'h84;
  localparam logic [REG_W-1:0]  PAGE_LANES = 8'h04;

  typedef struct packed {
    logic [NUM_LANES-1:0][SEL_W-1:0] laneSel;
    logic [NUM_LANES-1:0]            laneEn;
  } xbar_ctrl_t;
endpackage

// File: rtl/lane_xbar_regs.sv
module lane_xbar_regs
  import lane_xbar_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  output xbar_ctrl_t        ctrl
);
  logic [REG_W-1:0] pageReg;
  logic [REG_W-1:0] enReg;
  logic [REG_W-1:0] selReg [NUM_SEL_REGS];
  logic             pageOk;

  assign pageOk = (pageReg == PAGE_LANES);

  always_ff @(posedge clk) begin
    if (rst) pageReg <= '0;
    else if (regWrEn && regAddr == ADDR_PAGE) pageReg <= regWrData;
  end

  always_ff @(posedge clk) begin
    if (rst) enReg <= '1;
    else if (regWrEn && pageOk && regAddr == ADDR_EN) enReg <= regWrData;
  end

  for (genvar i = 0; i < NUM_SEL_REGS; i++) begin : g_sel
    localparam logic [SEL_W-1:0] LO_RST = SEL_W'(2 * i);
    localparam logic [SEL_W-1:0] HI_RST = SEL_W'(2 * i + 1);
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_SEL0 + ADDR_W'(i);
    logic wrHit;
    assign wrHit = regWrEn && pageOk && (regAddr == MY_ADDR);

    always_ff @(posedge clk) begin
      if (rst) selReg[i] <= {1'b0, HI_RST, 1'b0, LO_RST};
      else if (wrHit) selReg[i] <= {1'b0, regWrData[6:4], 1'b0, regWrData[2:0]};
    end

    assign ctrl.laneSel[2*i]   = selReg[i][SEL_W-1:0];
    assign ctrl.laneSel[2*i+1] = selReg[i][4 +: SEL_W];

    // R3: a write outside the lane page leaves the register untouched
    p_page_gate_r3: assert property (@(posedge clk) disable iff (rst)
      (regWrEn && regAddr == MY_ADDR && !pageOk) |=> $stable(selReg[i]));

    // R4: an accepted write lands in both nibbles
    p_write_lands_r4: assert property (@(posedge clk) disable iff (rst)
      (regWrEn && regAddr == MY_ADDR && pageOk) |=>
      (ctrl.laneSel[2*i] == $past(regWrData[2:0]) &&
       ctrl.laneSel[2*i+1] == $past(regWrData[6:4])));

    // R1: identity routing right after reset
    p_reset_identity_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (ctrl.laneSel[2*i] == LO_RST && ctrl.laneSel[2*i+1] == HI_RST));
  end

  assign ctrl.laneEn = enReg;

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_PAGE) regRdData = pageReg;
    else if (pageOk && regAddr == ADDR_EN) regRdData = enReg;
    else if (pageOk) begin
      for (int i = 0; i < NUM_SEL_REGS; i++)
        if (regAddr == ADDR_SEL0 + ADDR_W'(i)) regRdData = selReg[i];
    end
  end

  // R5: reserved select bits never read as one
  p_reserved_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (regAddr >= ADDR_SEL0 && regAddr < ADDR_EN) |-> (regRdData[3] == 1'b0 && regRdData[7] == 1'b0));

  // R2: all lanes enabled right after reset
  p_reset_enabled_r2: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ctrl.laneEn == '1));
endmodule

// File: rtl/lane_xbar_route.sv
module lane_xbar_route
  import lane_xbar_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  xbar_ctrl_t                    ctrl,
  input  logic [NUM_LANES*DATA_W-1:0]   laneInData,
  input  logic [NUM_LANES-1:0]          laneInValid,
  output logic [NUM_LANES*DATA_W-1:0]   laneOutData,
  output logic [NUM_LANES-1:0]          laneOutValid
);
  logic [DATA_W-1:0] inWord [NUM_LANES];

  for (genvar s = 0; s < NUM_LANES; s++) begin : g_unpack
    assign inWord[s] = laneInData[s*DATA_W +: DATA_W];
  end

  for (genvar n = 0; n < NUM_LANES; n++) begin : g_lane
    logic [SEL_W-1:0] sel;
    logic             en;
    assign sel = ctrl.laneSel[n];
    assign en  = ctrl.laneEn[n];

    always_ff @(posedge clk) begin
      if (rst) begin
        laneOutData[n*DATA_W +: DATA_W] <= '0;
        laneOutValid[n]                 <= 1'b0;
      end else begin
        laneOutData[n*DATA_W +: DATA_W] <= en ? inWord[sel] : '0;
        laneOutValid[n]                 <= en & laneInValid[sel];
      end
    end

    // R6: a valid word only leaves an enabled lane
    p_valid_needs_en_r6: assert property (@(posedge clk) disable iff (rst)
      laneOutValid[n] |-> $past(en));

    // R6: a disabled lane stays at zero
    p_off_lane_quiet_r6: assert property (@(posedge clk) disable iff (rst)
      $past(!en) |-> (laneOutData[n*DATA_W +: DATA_W] == '0));
  end
endmodule

// File: rtl/lane_xbar.sv
module lane_xbar
  import lane_xbar_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          regWrEn,
  input  logic [ADDR_W-1:0]             regAddr,
  input  logic [REG_W-1:0]              regWrData,
  output logic [REG_W-1:0]              regRdData,
  input  logic [NUM_LANES*DATA_W-1:0]   laneInData,
  input  logic [NUM_LANES-1:0]          laneInValid,
  output logic [NUM_LANES*DATA_W-1:0]   laneOutData,
  output logic [NUM_LANES-1:0]          laneOutValid,
  output logic [NUM_LANES-1:0]          laneOutEn
);
  xbar_ctrl_t ctrl;

  lane_xbar_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .ctrl      (ctrl)
  );

  lane_xbar_route #(.DATA_W(DATA_W)) u_route (
    .clk          (clk),
    .rst          (rst),
    .ctrl         (ctrl),
    .laneInData   (laneInData),
    .laneInValid  (laneInValid),
    .laneOutData  (laneOutData),
    .laneOutValid (laneOutValid)
  );

  assign laneOutEn = ctrl.laneEn;
endmodule

// File: tb/lane_xbar_bench.sv
module lane_xbar_bench;
  localparam int L  = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic          regWrEn;
  logic [7:0]    regAddr;
  logic [7:0]    regWrData;
  logic [7:0]    regRdData;
  logic [L*DW-1:0] laneInData;
  logic [L-1:0]  laneInValid;
  logic [L*DW-1:0] laneOutData;
  logic [L-1:0]  laneOutValid;
  logic [L-1:0]  laneOutEn;

  int testsRun = 0;
  int testsFailed = 0;
  logic [2:0] expSel [L];
  logic [7:0] expEn;
  logic [15:0] prevIn [L];

  always #4 clk = ~clk;

  lane_xbar #(.DATA_W(DW)) u_lane_xbar (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .laneInData(laneInData),
    .laneInValid(laneInValid), .laneOutData(laneOutData),
    .laneOutValid(laneOutValid), .laneOutEn(laneOutEn)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    regAddr = a;
    #1;
    chk(req, {24'h0, regRdData}, {24'h0, exp});
  endtask

  function automatic logic [15:0] pat(input int s, input logic [15:0] base);
    return base ^ (16'(s) * 16'h1111);
  endfunction

  task automatic drive(input logic [15:0] base, input logic [7:0] vld);
    for (int s = 0; s < L; s++) laneInData[s*DW +: DW] = pat(s, base);
    laneInValid = vld;
  endtask

  // Apply a pattern, let one edge pass, compare every lane against the model
  task automatic route_chk(input string req, input logic [15:0] base, input logic [7:0] vld);
    @(negedge clk);
    drive(base, vld);
    @(negedge clk);
    for (int n = 0; n < L; n++) begin
      logic [15:0] ed;
      logic        ev;
      ed = expEn[n] ? pat(int'(expSel[n]), base) : 16'h0;
      ev = expEn[n] & vld[expSel[n]];
      chk(req, {15'h0, laneOutValid[n], laneOutData[n*DW +: DW]}, {15'h0, ev, ed});
    end
  endtask

  task automatic t_reset;
    for (int n = 0; n < L; n++) expSel[n] = 3'(n);
    expEn = 8'hFF;
    route_chk("R1 identity after reset", 16'h0A00, 8'hFF);
    chk("R2 enables after reset", {24'h0, laneOutEn}, 32'hFF);
    rd("R3 page reset value", 8'h05, 8'h00);
    rd("R3 hidden read off page", 8'h80, 8'h00);
    wr(8'h05, 8'h04);
    rd("R1 sel reg 0x80 reset", 8'h80, 8'h10);
    rd("R1 sel reg 0x83 reset", 8'h83, 8'h76);
    rd("R2 enable reg reset", 8'h84, 8'hFF);
    rd("R3 page readback", 8'h05, 8'h04);
  endtask

  task automatic t_page_gate;
    wr(8'h05, 8'h03);
    wr(8'h81, 8'h54);
    wr(8'h84, 8'h00);
    route_chk("R3 routing unchanged off page", 16'h5A00, 8'hFF);
    chk("R3 enables unchanged off page", {24'h0, laneOutEn}, 32'hFF);
    wr(8'h05, 8'h04);
    rd("R3 sel reg unchanged", 8'h81, 8'h32);
    rd("R3 enable unchanged", 8'h84, 8'hFF);
  endtask

  task automatic t_nibbles;
    wr(8'h81, 8'h54); expSel[2] = 3'd4; expSel[3] = 3'd5;
    wr(8'h82, 8'h32); expSel[4] = 3'd2; expSel[5] = 3'd3;
    rd("R9 readback 0x81", 8'h81, 8'h54);
    rd("R9 readback 0x82", 8'h82, 8'h32);
    route_chk("R4 lane 2..5 swap", 16'h3C00, 8'hFF);
    wr(8'h83, 8'h07); expSel[6] = 3'd7; expSel[7] = 3'd0;
    route_chk("R4 lanes 6 and 7", 16'h7700, 8'hFF);
  endtask

  task automatic t_reserved;
    wr(8'h80, 8'hFF); expSel[0] = 3'd7; expSel[1] = 3'd7;
    rd("R5 reserved bits zero", 8'h80, 8'h77);
    route_chk("R5 reserved bits ignored", 16'h1200, 8'hFF);
  endtask

  task automatic t_broadcast;
    for (int k = 0; k < 4; k++) wr(8'h80 + 8'(k), 8'h66);
    for (int n = 0; n < L; n++) expSel[n] = 3'd6;
    route_chk("R8 broadcast stream 6 valid", 16'hB000, 8'h40);
    route_chk("R8 broadcast stream 6 invalid", 16'hB100, 8'hBF);
    wr(8'h80, 8'h21); expSel[0] = 3'd1; expSel[1] = 3'd2;
    wr(8'h81, 8'h43); expSel[2] = 3'd3; expSel[3] = 3'd4;
    route_chk("R8 mixed valid pattern", 16'hC300, 8'h0F);
  endtask

  task automatic t_enable;
    wr(8'h84, 8'hA5); expEn = 8'hA5;
    rd("R9 enable readback", 8'h84, 8'hA5);
    chk("R6 enable flags", {24'h0, laneOutEn}, 32'hA5);
    route_chk("R6 disabled lanes quiet", 16'hEE00, 8'hFF);
    wr(8'h84, 8'hFF); expEn = 8'hFF;
    route_chk("R6 lanes re-enabled", 16'hEF00, 8'hFF);
  endtask

  task automatic t_latency;
    // model: lane 0 currently fed by stream 1, now rerouted to stream 5
    @(negedge clk);
    drive(16'h4400, 8'hFF);
    regWrEn = 1'b1; regAddr = 8'h80; regWrData = {1'b0, expSel[1], 1'b0, 3'd5};
    @(negedge clk);
    regWrEn = 1'b0;
    chk("R7 old routing at write edge", {16'h0, laneOutData[0 +: DW]}, {16'h0, pat(int'(expSel[0]), 16'h4400)});
    expSel[0] = 3'd5;
    drive(16'h4500, 8'hFF);
    @(negedge clk);
    chk("R7 new routing one edge later", {16'h0, laneOutData[0 +: DW]}, {16'h0, pat(5, 16'h4500)});
    drive(16'h4600, 8'hFF);
    chk("R7 output holds until edge", {16'h0, laneOutData[0 +: DW]}, {16'h0, pat(5, 16'h4500)});
    @(negedge clk);
    chk("R7 one edge input latency", {16'h0, laneOutData[0 +: DW]}, {16'h0, pat(5, 16'h4600)});
  endtask

  initial begin
    rst = 1'b1; regWrEn = 1'b0; regAddr = 8'h00; regWrData = 8'h00;
    laneInData = '0; laneInValid = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_page_gate();
    t_nibbles();
    t_reserved();
    t_broadcast();
    t_enable();
    t_latency();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #200000;
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule